// File: doc/BRIEF.md
# UART Receive Queue with Trigger Interrupt

This block buffers received characters for a UART. Characters reach it from the serial deserializer or, when loopback is on, from the transmit side. A single-cycle read strobe on the data register removes the oldest entry. Each stored entry is 12 bits wide: bits 7:0 hold the character and bits 11:8 hold its status (bit 8 framing error, bit 9 parity error, bit 10 break, bit 11 overrun). The block tracks a read pointer and an occupancy count. From these it drives empty and full flags, a raw receive interrupt that moves at the trigger crossings, and a receive-status register that takes the status of each popped entry.

A configuration write selects the queue mode. With the enable bit set, the queue holds `DEPTH` (16) entries. With it clear, it holds one entry. Any configuration write that changes the mode empties the queue. After reset the block is in one-entry mode. A line-break event in one-entry mode stores a break word and marks a break in the status register.

Top module: `uart_rxq`

## Requirements
- R1: After reset, rx_empty=1, rx_full=0, rx_irq_raw=0, rx_overrun=0, fifo_mode=0 (one-entry mode), rx_status=0 and rd_data=0.
- R2: With fifo_mode=1 the queue accepts 16 entries and raises rx_full on the edge that stores the 16th. A push arriving while rx_full is high is discarded, and rx_overrun pulses high for one cycle on the next edge.
- R3: With fifo_mode=0 a single push raises rx_full. A second push before a read is discarded and pulses rx_overrun.
- R4: Reads return entries oldest first. rd_data is updated on the clock edge that samples rd_en, with bits 7:0 the character and bits 11:8 its status.
- R5: A read on an empty queue leaves the count and rx_empty unchanged. It returns the entry stored at the current read position.
- R6: rx_irq_raw sets when a push makes the count equal to TRIG_LEVEL (1). It clears when a read leaves the count at TRIG_LEVEL-1, and this includes a read of an empty queue. If both happen in the same cycle, the set wins. A mode flush does not change it.
- R7: A configuration write whose cfg_fifo_en differs from fifo_mode takes effect on the next edge. It empties the queue, resets the read position and updates fifo_mode, and it discards any push or read in that same cycle. A write with an unchanged value has no effect.
- R8: One edge after rd_data changes for a read, rx_status loads bits 11:8 of that entry. stat_clr zeroes rx_status on the next edge and wins over any load or break in the same cycle.
- R9: In one-entry mode, brk_event pushes the word 0x400 (only bit 10 set) and sets rx_status bit 2. It takes priority over the other push sources in that cycle. In 16-entry mode brk_event is ignored.
- R10: While lb_en=1, lb_valid pushes {4'h0, lb_data} and ser_valid is ignored. While lb_en=0, lb_valid is ignored.
- R11: A push and a read in the same cycle both take effect, with the read seeing the old entry. Whether the push is accepted depends on rx_full at the start of the cycle, so a push into a full queue is dropped even when a read happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_valid | input | 1 | Deserializer has a character |
| ser_data | input | 8 | Deserializer character |
| ser_err | input | 4 | Deserializer status bits for the character |
| lb_en | input | 1 | Loopback mode select |
| lb_valid | input | 1 | Loopback character strobe |
| lb_data | input | 8 | Loopback character |
| brk_event | input | 1 | Line-break event |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_fifo_en | input | 1 | Queue-enable value of the configuration write |
| rd_en | input | 1 | Data register read strobe |
| stat_clr | input | 1 | Write to the receive-status register (clears it) |
| rd_data | output | 12 | Popped entry |
| rx_status | output | 4 | Receive-status register |
| fifo_mode | output | 1 | 1 = 16-entry mode, 0 = one-entry mode |
| rx_empty | output | 1 | Queue empty |
| rx_full | output | 1 | Queue full |
| rx_irq_raw | output | 1 | Raw receive interrupt |
| rx_overrun | output | 1 | One-cycle pulse for a discarded push |

## Verification
The assertions check the following on every cycle:
- rx_empty and rx_full are never both high.
- A mode-toggling write leaves an empty queue in the new mode.
- An overrun pulse only follows a full cycle.
- The interrupt rises only with a non-empty queue and falls only after a read.
- A status clear always yields zero.

The bench runs a behavioural reference model against the outputs on every cycle. Only its scenarios can show entry ordering, the stale entry returned by a read of an empty queue, the lag between rd_data and rx_status, and the source priority between break, loopback and deserializer pushes.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int RXQ_DATA_W = 8;
  localparam int RXQ_STAT_W = 4;
  // status bit index marking a line break
  localparam int RXQ_BRK_IDX = 2;

  function automatic logic [RXQ_DATA_W+RXQ_STAT_W-1:0] brk_word();
    brk_word = '0;
    brk_word[RXQ_DATA_W+RXQ_BRK_IDX] = 1'b1;
  endfunction
endpackage

// File: rtl/uart_rxq_src.sv
module uart_rxq_src #(
  parameter int DATA_W = 8,
  parameter int STAT_W = 4,
  localparam int ENTRY_W = DATA_W + STAT_W
) (
  input  logic               mode_fifo,
  input  logic               brk_event,
  input  logic               lb_en,
  input  logic               lb_valid,
  input  logic [DATA_W-1:0]  lb_data,
  input  logic               ser_valid,
  input  logic [DATA_W-1:0]  ser_data,
  input  logic [STAT_W-1:0]  ser_err,
  output logic               push_req,
  output logic [ENTRY_W-1:0] push_entry,
  output logic               brk_hit
);
  always_comb begin
    brk_hit  = brk_event && !mode_fifo;
    push_req = brk_hit || (lb_en ? lb_valid : ser_valid);
    if (brk_hit)
      push_entry = uart_rxq_pkg::brk_word();
    else if (lb_en)
      push_entry = {{STAT_W{1'b0}}, lb_data};
    else
      push_entry = {ser_err, ser_data};
  end
endmodule

// File: rtl/uart_rxq_mem.sv
module uart_rxq_mem #(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 12,
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [PTR_W-1:0]   waddr,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic               re,
  input  logic [PTR_W-1:0]   raddr,
  output logic [ENTRY_W-1:0] rdata
);
  logic [ENTRY_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl #(
  parameter int DEPTH      = 16,
  parameter int TRIG_LEVEL = 1,
  localparam int PTR_W     = $clog2(DEPTH),
  localparam int CNT_W     = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_fifo_en,
  input  logic             push_req,
  input  logic             rd_en,
  output logic             mode_q,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [PTR_W-1:0] rd_addr,
  output logic             rd_fire,
  output logic             empty_q,
  output logic             full_q,
  output logic             irq_q,
  output logic             ovr_q
);
  logic [CNT_W-1:0] cnt_q, cnt_mid, cnt_nx, depth_cur;
  logic [PTR_W-1:0] rp_q, rp_nx, mask;
  logic             flush, take, pop, irq_nx;

  always_comb begin
    depth_cur = mode_q ? CNT_W'(DEPTH) : CNT_W'(1);
    mask      = mode_q ? PTR_W'(DEPTH - 1) : '0;
    flush     = cfg_wr && (cfg_fifo_en != mode_q);
    take      = push_req && !full_q && !flush;
    rd_fire   = rd_en && !flush;
    pop       = rd_fire && (cnt_q != '0);
    cnt_mid   = cnt_q - CNT_W'(pop);
    cnt_nx    = cnt_mid + CNT_W'(take);
    rp_nx     = pop ? ((rp_q + PTR_W'(1)) & mask) : rp_q;
    wr_en     = take;
    wr_addr   = (rp_q + cnt_q[PTR_W-1:0]) & mask;
    rd_addr   = rp_q;
    irq_nx    = irq_q;
    if (rd_fire && cnt_mid == CNT_W'(TRIG_LEVEL - 1)) irq_nx = 1'b0;
    if (take && cnt_nx == CNT_W'(TRIG_LEVEL))         irq_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      rp_q    <= '0;
      mode_q  <= 1'b0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      irq_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (flush) begin
      cnt_q   <= '0;
      rp_q    <= '0;
      mode_q  <= cfg_fifo_en;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_nx;
      rp_q    <= rp_nx;
      empty_q <= (cnt_nx == '0);
      full_q  <= (cnt_nx == depth_cur);
      irq_q   <= irq_nx;
      ovr_q   <= push_req && full_q;
    end
  end
endmodule

// File: rtl/uart_rxq_stat.sv
module uart_rxq_stat #(
  parameter int STAT_W  = 4,
  parameter int BRK_IDX = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              rd_fire,
  input  logic [STAT_W-1:0] popped_stat,
  input  logic              brk_set,
  output logic [STAT_W-1:0] status_q
);
  localparam logic [STAT_W-1:0] BRK_MASK = STAT_W'(1) << BRK_IDX;

  logic              pend_q;
  logic [STAT_W-1:0] status_nx;

  always_comb begin
    status_nx = pend_q ? popped_stat : status_q;
    if (brk_set) status_nx = status_nx | BRK_MASK;
    if (clr)     status_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      status_q <= '0;
    end else begin
      pend_q   <= rd_fire;
      status_q <= status_nx;
    end
  end
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq #(
  parameter int DEPTH      = 16,
  parameter int TRIG_LEVEL = 1,
  parameter int DATA_W     = uart_rxq_pkg::RXQ_DATA_W,
  parameter int STAT_W     = uart_rxq_pkg::RXQ_STAT_W,
  localparam int ENTRY_W   = DATA_W + STAT_W,
  localparam int PTR_W     = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_valid,
  input  logic [DATA_W-1:0]  ser_data,
  input  logic [STAT_W-1:0]  ser_err,
  input  logic               lb_en,
  input  logic               lb_valid,
  input  logic [DATA_W-1:0]  lb_data,
  input  logic               brk_event,
  input  logic               cfg_wr,
  input  logic               cfg_fifo_en,
  input  logic               rd_en,
  input  logic               stat_clr,
  output logic [ENTRY_W-1:0] rd_data,
  output logic [STAT_W-1:0]  rx_status,
  output logic               fifo_mode,
  output logic               rx_empty,
  output logic               rx_full,
  output logic               rx_irq_raw,
  output logic               rx_overrun
);
  logic               push_req, brk_hit, wr_en, rd_fire;
  logic [ENTRY_W-1:0] push_entry;
  logic [PTR_W-1:0]   wr_addr, rd_addr;

  uart_rxq_src #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_src (
    .mode_fifo (fifo_mode),
    .brk_event (brk_event),
    .lb_en     (lb_en),
    .lb_valid  (lb_valid),
    .lb_data   (lb_data),
    .ser_valid (ser_valid),
    .ser_data  (ser_data),
    .ser_err   (ser_err),
    .push_req  (push_req),
    .push_entry(push_entry),
    .brk_hit   (brk_hit)
  );

  uart_rxq_ctrl #(.DEPTH(DEPTH), .TRIG_LEVEL(TRIG_LEVEL)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_fifo_en(cfg_fifo_en),
    .push_req   (push_req),
    .rd_en      (rd_en),
    .mode_q     (fifo_mode),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .rd_addr    (rd_addr),
    .rd_fire    (rd_fire),
    .empty_q    (rx_empty),
    .full_q     (rx_full),
    .irq_q      (rx_irq_raw),
    .ovr_q      (rx_overrun)
  );

  uart_rxq_mem #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_mem (
    .clk  (clk),
    .rst  (rst),
    .we   (wr_en),
    .waddr(wr_addr),
    .wdata(push_entry),
    .re   (rd_fire),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

  uart_rxq_stat #(.STAT_W(STAT_W), .BRK_IDX(uart_rxq_pkg::RXQ_BRK_IDX)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .clr        (stat_clr),
    .rd_fire    (rd_fire),
    .popped_stat(rd_data[ENTRY_W-1:DATA_W]),
    .brk_set    (brk_hit),
    .status_q   (rx_status)
  );
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
  parameter int STAT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic              cfg_fifo_en,
  input logic              rd_en,
  input logic              stat_clr,
  input logic              fifo_mode,
  input logic              rx_empty,
  input logic              rx_full,
  input logic              rx_irq_raw,
  input logic              rx_overrun,
  input logic [STAT_W-1:0] rx_status
);
  // R2: the two occupancy flags exclude each other
  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rx_empty && rx_full));

  // R2: a discarded push can only follow a full cycle
  a_r2_overrun_after_full: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |-> $past(rx_full));

  // R7: a mode toggle leaves an empty queue in the new mode
  a_r7_toggle_flushes: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && (cfg_fifo_en != fifo_mode)) |=>
      (rx_empty && !rx_full && (fifo_mode == $past(cfg_fifo_en))));

  // R5: the queue only turns empty through a read or a configuration write
  a_r5_empty_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_empty) |-> $past(rd_en || cfg_wr));

  // R6: the interrupt rises only with data present
  a_r6_irq_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_irq_raw) |-> !rx_empty);

  // R6: the interrupt falls only after a read
  a_r6_irq_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_irq_raw) |-> $past(rd_en));

  // R8: a status write always leaves zero
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    stat_clr |=> (rx_status == '0));
endmodule

bind uart_rxq uart_rxq_chk #(.STAT_W(STAT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_wr     (cfg_wr),
  .cfg_fifo_en(cfg_fifo_en),
  .rd_en      (rd_en),
  .stat_clr   (stat_clr),
  .fifo_mode  (fifo_mode),
  .rx_empty   (rx_empty),
  .rx_full    (rx_full),
  .rx_irq_raw (rx_irq_raw),
  .rx_overrun (rx_overrun),
  .rx_status  (rx_status)
);

// File: tb/uart_rxq_test.sv
module uart_rxq_test;
  localparam int DEPTH = 16;
  localparam int TRIG  = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_valid = 0, lb_en = 0, lb_valid = 0, brk_event = 0;
  logic        cfg_wr = 0, cfg_fifo_en = 0, rd_en = 0, stat_clr = 0;
  logic [7:0]  ser_data = 0, lb_data = 0;
  logic [3:0]  ser_err = 0;
  logic [11:0] rd_data;
  logic [3:0]  rx_status;
  logic        fifo_mode, rx_empty, rx_full, rx_irq_raw, rx_overrun;

  always #5 clk = ~clk;

  uart_rxq uut (
    .clk(clk), .rst(rst), .ser_valid(ser_valid), .ser_data(ser_data),
    .ser_err(ser_err), .lb_en(lb_en), .lb_valid(lb_valid), .lb_data(lb_data),
    .brk_event(brk_event), .cfg_wr(cfg_wr), .cfg_fifo_en(cfg_fifo_en),
    .rd_en(rd_en), .stat_clr(stat_clr), .rd_data(rd_data),
    .rx_status(rx_status), .fifo_mode(fifo_mode), .rx_empty(rx_empty),
    .rx_full(rx_full), .rx_irq_raw(rx_irq_raw), .rx_overrun(rx_overrun)
  );

  // behavioural reference state
  int          m_cnt, m_rp;
  bit          m_mode, m_irq, m_ovr, m_pend;
  logic [11:0] m_mem [DEPTH];
  bit          m_known [DEPTH];
  logic [11:0] m_rd;
  bit          m_rd_known;
  logic [3:0]  m_st;
  bit          m_st_known;

  int    n_checks = 0, n_fails = 0;
  bit    done = 0;
  string tag = "R1";

  task automatic model_reset();
    m_cnt = 0; m_rp = 0; m_mode = 0; m_irq = 0; m_ovr = 0; m_pend = 0;
    m_rd = '0; m_rd_known = 1; m_st = '0; m_st_known = 1;
    for (int i = 0; i < DEPTH; i++) m_known[i] = 0;
  endtask

  task automatic model_step();
    int depth, mask, slot;
    bit flush, brk_hit, preq, full_start;
    logic [11:0] ent;
    depth   = m_mode ? DEPTH : 1;
    mask    = depth - 1;
    flush   = cfg_wr && (cfg_fifo_en != m_mode);
    brk_hit = brk_event && !m_mode;
    if (stat_clr) begin
      m_st = '0; m_st_known = 1;
    end else begin
      if (m_pend) begin m_st = m_rd[11:8]; m_st_known = m_rd_known; end
      if (brk_hit) m_st[2] = 1'b1;
    end
    m_pend = rd_en && !flush;
    if (flush) begin
      m_cnt = 0; m_rp = 0; m_mode = cfg_fifo_en; m_ovr = 0;
    end else begin
      preq = brk_hit || (lb_en ? lb_valid : ser_valid);
      if (brk_hit)    ent = 12'h400;
      else if (lb_en) ent = {4'h0, lb_data};
      else            ent = {ser_err, ser_data};
      full_start = (m_cnt == depth);
      slot = (m_rp + m_cnt) & mask;
      if (rd_en) begin
        m_rd = m_mem[m_rp]; m_rd_known = m_known[m_rp];
        if (m_cnt > 0) begin m_cnt--; m_rp = (m_rp + 1) & mask; end
        if (m_cnt == TRIG - 1) m_irq = 0;
      end
      if (preq && !full_start) begin
        m_mem[slot] = ent; m_known[slot] = 1; m_cnt++;
        if (m_cnt == TRIG) m_irq = 1;
      end
      m_ovr = preq && full_start;
    end
  endtask

  task automatic chk(string fld, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s (scenario %s) t=%0t: actual %0h expected %0h",
               req, fld, tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    int depth;
    depth = m_mode ? DEPTH : 1;
    chk("rx_empty",   "R2", 32'(rx_empty),   32'(m_cnt == 0));
    chk("rx_full",    "R2", 32'(rx_full),    32'(m_cnt == depth));
    chk("rx_overrun", "R2", 32'(rx_overrun), 32'(m_ovr));
    chk("rx_irq_raw", "R6", 32'(rx_irq_raw), 32'(m_irq));
    chk("fifo_mode",  "R7", 32'(fifo_mode),  32'(m_mode));
    if (m_rd_known) chk("rd_data",   "R4", 32'(rd_data),   32'(m_rd));
    if (m_st_known) chk("rx_status", "R8", 32'(rx_status), 32'(m_st));
  endtask

  task automatic idle();
    ser_valid = 0; lb_valid = 0; brk_event = 0; cfg_wr = 0;
    rd_en = 0; stat_clr = 0;
  endtask

  // inputs are set at a falling edge; one clock, then compare at the next falling edge
  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic push_ser(input logic [7:0] d, input logic [3:0] e);
    ser_valid = 1; ser_data = d; ser_err = e; cycle();
  endtask
  task automatic do_read();
    rd_en = 1; cycle();
  endtask
  task automatic set_mode(input bit en);
    cfg_wr = 1; cfg_fifo_en = en; cycle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    tag = "R1"; compare(); cycle(); cycle();

    tag = "R3";
    push_ser(8'h5A, 4'h3);
    push_ser(8'h11, 4'h0);          // dropped, overrun pulse
    cycle();
    tag = "R8";
    do_read(); cycle(); cycle();     // status loads one edge after rd_data
    stat_clr = 1; cycle();
    tag = "R5";
    do_read(); do_read(); cycle();   // reads of an empty queue
    tag = "R9";
    brk_event = 1; ser_valid = 1; ser_data = 8'h77; cycle();
    do_read(); cycle();
    stat_clr = 1; rd_en = 1; cycle(); cycle(); // clear vs pending load

    tag = "R7";
    push_ser(8'h21, 4'h0);
    set_mode(1'b0);                  // same value: no effect
    set_mode(1'b1);                  // toggles: flush
    tag = "R9";
    brk_event = 1; cycle();          // ignored in 16-entry mode
    tag = "R2";
    for (int i = 0; i < DEPTH + 2; i++) push_ser(8'(i * 7 + 1), 4'(i));
    tag = "R11";
    ser_valid = 1; ser_data = 8'hEE; rd_en = 1; cycle();
    ser_valid = 1; ser_data = 8'hEF; rd_en = 1; cycle();
    tag = "R4";
    for (int i = 0; i < DEPTH + 2; i++) do_read();
    tag = "R10";
    lb_en = 1;
    lb_valid = 1; lb_data = 8'hC3; ser_valid = 1; ser_data = 8'h3C; cycle();
    ser_valid = 1; ser_data = 8'h99; cycle();
    lb_en = 0;
    lb_valid = 1; lb_data = 8'h55; cycle();
    do_read(); do_read(); cycle();
    tag = "R6";
    push_ser(8'h01, 4'h8); do_read(); push_ser(8'h02, 4'h0);
    set_mode(1'b0); do_read(); cycle();

    tag = "R11";
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 50) == 0) lb_en = ~lb_en;
      ser_valid   = ($urandom % 10) < 4;
      ser_data    = 8'($urandom);
      ser_err     = 4'($urandom);
      lb_valid    = ($urandom % 10) < 3;
      lb_data     = 8'($urandom);
      brk_event   = ($urandom % 30) == 0;
      rd_en       = ($urandom % 10) < 4;
      stat_clr    = ($urandom % 20) == 0;
      cfg_wr      = ($urandom % 60) == 0;
      cfg_fifo_en = 1'($urandom);
      cycle();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule